// File: doc/BRIEF.md
# DMA Channel Flow Sequencer

This block sequences a single DMA channel. Software loads four channel registers: source address, destination address, next-item pointer and a control word. It then pulses an enable. The channel waits for the request that matches its transfer kind. Each beat waits for the arbitration grant, then makes one single-word read at the source address and one single-word write of that data at the destination address. The source and destination addresses advance after the beat when their increment bits are set.

Either the engine or the peripheral decides when the transfer ends. Under engine flow control, the count in the control word falls by one per beat and the transfer ends on the beat that takes it from one to zero. Under peripheral flow control, the count is left alone and the transfer ends on the beat whose request carried the "last" flag. At the end, the involved peripheral gets a one-cycle acknowledge and a maskable terminal-count interrupt fires. A nonzero next-item pointer then triggers four word reads that reload the channel registers, and the channel re-arms without software. A bus error stops the channel and raises a maskable error interrupt.

Control word layout: count in bits [CNT_W-1:0], error-interrupt enable bit 25, source increment bit 26, destination increment bit 27, transfer kind bits [29:28] (0 memory-to-memory, 1 memory-to-peripheral, 2 peripheral-to-memory, 3 peripheral-to-peripheral), peripheral-flow bit 30, terminal-count interrupt enable bit 31. The register select codes for configuration writes are 0 source, 1 destination, 2 next pointer, 3 control.

Top module: `dma_seq_top`

## Requirements
- R1: Configuration writes (cfg_sel 0 source, 1 destination, 2 pointer, 3 control) take effect only while ch_active is low. A write made while the channel is active is ignored.
- R2: After en_set, ch_active rises and no bus access happens until the matching request arrives: dst_req for kind 1, src_req for kinds 2 and 3. Kind 0 needs no request.
- R3: No beat's read starts unless arb_grant was high in the cycle before bus_req rose.
- R4: Each beat reads the source address and then writes the read data to the destination address. Each address advances by 4 after the beat when its increment bit (26 source, 27 destination) is set, and stays put otherwise. bus_addr and bus_we hold steady until bus_done.
- R5: With bit 30 clear, the transfer ends after exactly count beats. With bit 30 set, the count is ignored and the transfer ends on the beat whose request had its last flag set.
- R6: On completion, a one-cycle src_ack goes out for kinds 2 and 3 and a one-cycle dst_ack for kinds 1 and 3. irq_tc pulses for one cycle if bit 31 is set. irq_tc and irq_err never fire together.
- R7: On completion with a nonzero pointer, four word reads at pointer, pointer+4, +8 and +12 load source, destination, pointer and control, and the channel waits for a request again. With a zero pointer, ch_active falls. No bus access occurs while ch_active is low.
- R8: bus_done with bus_err stops the channel: ch_active falls, no further access is made, and irq_err pulses if bit 25 is set.
- R9: en_clr drops ch_active at the next beat boundary. A channel waiting for a request stops at once, and a beat in progress finishes its write. No terminal-count interrupt is raised unless that beat was the last.
- R10: Kind 0 always uses engine flow control, whatever bit 30 holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_sel | input | 2 | Register select for the write |
| cfg_wdata | input | DW | Write data |
| en_set | input | 1 | Enable pulse |
| en_clr | input | 1 | Disable pulse |
| ch_active | output | 1 | Channel enabled status |
| src_req | input | 1 | Source peripheral request |
| src_last | input | 1 | Source request marks the final beat |
| dst_req | input | 1 | Destination peripheral request |
| dst_last | input | 1 | Destination request marks the final beat |
| src_ack | output | 1 | Completion acknowledge to source peripheral |
| dst_ack | output | 1 | Completion acknowledge to destination peripheral |
| arb_pending | output | 1 | Channel has a beat waiting for grant |
| arb_grant | input | 1 | Highest priority and bus owned |
| bus_req | output | 1 | Bus access valid |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | DW | Access address |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data |
| bus_done | input | 1 | Access complete |
| bus_err | input | 1 | Access failed, valid with bus_done |
| irq_tc | output | 1 | Terminal-count interrupt pulse |
| irq_err | output | 1 | Error interrupt pulse |

## Verification
Memory-to-memory copies run with random lengths, random increment settings and the peripheral-flow bit set at random. These runs compare the destination memory and the beat count against a bench model, which separates address stepping from count handling. Request-paced runs use peripheral flow with the count set to one, so a channel that wrongly obeys the count stops early. A request on the wrong side shows whether the request is chosen by transfer kind. A chained item, a mid-transfer bus error with the mask on and off, and disables while waiting and while running cover reload, stop paths and interrupt masking.

// File: rtl/dma_seq_pkg.sv
// Shared encodings for the DMA channel sequencer: transfer kinds,
// control word field positions and sequencer states.
package dma_seq_pkg;
    typedef enum logic [1:0] {
        XT_M2M = 2'd0,
        XT_M2P = 2'd1,
        XT_P2M = 2'd2,
        XT_P2P = 2'd3
    } xfer_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_READ,
        ST_WRITE,
        ST_FETCH
    } seq_st_t;

    localparam int CW_ERRIE = 25;
    localparam int CW_SINC  = 26;
    localparam int CW_DINC  = 27;
    localparam int CW_KLO   = 28;
    localparam int CW_PFLOW = 30;
    localparam int CW_TCIE  = 31;
endpackage

// File: rtl/dma_seq_regs.sv
// Channel register set: source, destination, next pointer, control.
// Assumes: software writes only land while idle; item loads from the
// sequencer take precedence; beat updates step addresses and count.
module dma_seq_regs
    import dma_seq_pkg::*;
#(
    parameter int DW    = 32,
    parameter int CNT_W = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [1:0]    cfg_sel,
    input  logic [DW-1:0] cfg_wdata,
    input  logic          busy,
    input  logic          lli_wr,
    input  logic [1:0]    lli_sel,
    input  logic [DW-1:0] lli_data,
    input  logic          beat_done,
    input  logic          dec_en,
    output logic [DW-1:0] src_q,
    output logic [DW-1:0] dst_q,
    output logic [DW-1:0] lli_q,
    output logic [DW-1:0] ctrl_q
);
    localparam int STEP = DW / 8;

    logic          wr_any;
    logic [1:0]    wr_sel;
    logic [DW-1:0] wr_data;

    // Pick the load source: item fetch beats software writes.
    always_comb begin
        wr_any  = lli_wr || (cfg_wr && !busy);
        wr_sel  = lli_wr ? lli_sel : cfg_sel;
        wr_data = lli_wr ? lli_data : cfg_wdata;
    end

    // Register update: loads, then per-beat address/count stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= '0;
            dst_q  <= '0;
            lli_q  <= '0;
            ctrl_q <= '0;
        end else if (wr_any) begin
            case (wr_sel)
                2'd0:    src_q  <= wr_data;
                2'd1:    dst_q  <= wr_data;
                2'd2:    lli_q  <= wr_data;
                default: ctrl_q <= wr_data;
            endcase
        end else if (beat_done) begin
            if (ctrl_q[CW_SINC]) src_q <= src_q + DW'(STEP);
            if (ctrl_q[CW_DINC]) dst_q <= dst_q + DW'(STEP);
            if (dec_en) ctrl_q[CNT_W-1:0] <= ctrl_q[CNT_W-1:0] - CNT_W'(1);
        end
    end
endmodule

// File: rtl/dma_seq_reqsel.sv
// Request routing by transfer kind: which request starts a beat, which
// last flag ends the transfer, who is acknowledged, and whether the
// peripheral owns flow control. Memory-to-memory self-requests and
// always uses engine flow control.
module dma_seq_reqsel
    import dma_seq_pkg::*;
(
    input  xfer_t kind,
    input  logic  pflow_bit,
    input  logic  src_req,
    input  logic  src_last,
    input  logic  dst_req,
    input  logic  dst_last,
    output logic  req_hit,
    output logic  req_last,
    output logic  pflow_eff,
    output logic  ack_src_sel,
    output logic  ack_dst_sel
);
    // Decode request side and acknowledge targets per kind.
    always_comb begin
        req_hit     = 1'b0;
        req_last    = 1'b0;
        pflow_eff   = pflow_bit;
        ack_src_sel = 1'b0;
        ack_dst_sel = 1'b0;
        case (kind)
            XT_M2M: begin
                req_hit   = 1'b1;
                pflow_eff = 1'b0;
            end
            XT_M2P: begin
                req_hit     = dst_req;
                req_last    = dst_last;
                ack_dst_sel = 1'b1;
            end
            XT_P2M: begin
                req_hit     = src_req;
                req_last    = src_last;
                ack_src_sel = 1'b1;
            end
            default: begin
                req_hit     = src_req;
                req_last    = src_last;
                ack_src_sel = 1'b1;
                ack_dst_sel = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/dma_seq_fsm.sv
// Channel sequencer: wait for request and grant, read source, write
// destination, decide completion, fetch the next item or stop.
// Assumes the bus holds bus_done high for one cycle per access.
module dma_seq_fsm
    import dma_seq_pkg::*;
#(
    parameter int DW    = 32,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_set,
    input  logic             en_clr,
    input  logic             arb_grant,
    input  logic             req_hit,
    input  logic             req_last,
    input  logic             pflow_eff,
    input  logic             ack_src_sel,
    input  logic             ack_dst_sel,
    input  logic             tc_ie,
    input  logic             err_ie,
    input  logic [CNT_W-1:0] cnt,
    input  logic [DW-1:0]    src_q,
    input  logic [DW-1:0]    dst_q,
    input  logic [DW-1:0]    lli_q,
    input  logic [DW-1:0]    bus_rdata,
    input  logic             bus_done,
    input  logic             bus_err,
    output logic             ch_active,
    output logic             arb_pending,
    output logic             bus_req,
    output logic             bus_we,
    output logic [DW-1:0]    bus_addr,
    output logic [DW-1:0]    bus_wdata,
    output logic             beat_done,
    output logic             lli_wr,
    output logic [1:0]       lli_sel,
    output logic             src_ack,
    output logic             dst_ack,
    output logic             irq_tc,
    output logic             irq_err
);
    localparam int STEP = DW / 8;

    seq_st_t       st_q;
    logic [DW-1:0] data_q;
    logic [DW-1:0] base_q;
    logic [1:0]    fidx_q;
    logic          last_q;
    logic          abort_q;
    logic          abort;
    logic          complete;

    assign abort    = abort_q || en_clr;
    assign complete = pflow_eff ? last_q : (cnt == CNT_W'(1));

    // Bus and register-file strobes decoded from the current state.
    always_comb begin
        bus_req     = (st_q == ST_READ) || (st_q == ST_WRITE) || (st_q == ST_FETCH);
        bus_we      = (st_q == ST_WRITE);
        bus_wdata   = data_q;
        case (st_q)
            ST_READ:  bus_addr = src_q;
            ST_WRITE: bus_addr = dst_q;
            default:  bus_addr = base_q + DW'(fidx_q) * DW'(STEP);
        endcase
        beat_done   = (st_q == ST_WRITE) && bus_done && !bus_err;
        lli_wr      = (st_q == ST_FETCH) && bus_done && !bus_err;
        lli_sel     = fidx_q;
        arb_pending = (st_q == ST_WAIT) && req_hit && !abort;
    end

    // State, data hold, abort latch and one-cycle completion pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            data_q    <= '0;
            base_q    <= '0;
            fidx_q    <= '0;
            last_q    <= 1'b0;
            abort_q   <= 1'b0;
            ch_active <= 1'b0;
            src_ack   <= 1'b0;
            dst_ack   <= 1'b0;
            irq_tc    <= 1'b0;
            irq_err   <= 1'b0;
        end else begin
            src_ack <= 1'b0;
            dst_ack <= 1'b0;
            irq_tc  <= 1'b0;
            irq_err <= 1'b0;
            if (st_q == ST_IDLE) abort_q <= 1'b0;
            else if (en_clr)     abort_q <= 1'b1;
            case (st_q)
                ST_IDLE: if (en_set) begin
                    st_q      <= ST_WAIT;
                    ch_active <= 1'b1;
                end
                ST_WAIT: if (abort) begin
                    st_q      <= ST_IDLE;
                    ch_active <= 1'b0;
                end else if (req_hit && arb_grant) begin
                    st_q   <= ST_READ;
                    last_q <= req_last;
                end
                ST_READ: if (bus_done) begin
                    if (bus_err) begin
                        st_q      <= ST_IDLE;
                        ch_active <= 1'b0;
                        irq_err   <= err_ie;
                    end else begin
                        data_q <= bus_rdata;
                        st_q   <= ST_WRITE;
                    end
                end
                ST_WRITE: if (bus_done) begin
                    if (bus_err) begin
                        st_q      <= ST_IDLE;
                        ch_active <= 1'b0;
                        irq_err   <= err_ie;
                    end else if (complete) begin
                        src_ack <= ack_src_sel;
                        dst_ack <= ack_dst_sel;
                        irq_tc  <= tc_ie;
                        if (lli_q != '0) begin
                            base_q <= lli_q;
                            fidx_q <= 2'd0;
                            st_q   <= ST_FETCH;
                        end else begin
                            st_q      <= ST_IDLE;
                            ch_active <= 1'b0;
                        end
                    end else if (abort) begin
                        st_q      <= ST_IDLE;
                        ch_active <= 1'b0;
                    end else begin
                        st_q <= ST_WAIT;
                    end
                end
                ST_FETCH: if (bus_done) begin
                    if (bus_err) begin
                        st_q      <= ST_IDLE;
                        ch_active <= 1'b0;
                        irq_err   <= err_ie;
                    end else if (fidx_q == 2'd3) begin
                        st_q <= ST_WAIT;
                    end else begin
                        fidx_q <= fidx_q + 2'd1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dma_seq_top.sv
// One DMA channel: register set, request routing and sequencer.
// Assumes a single-word bus master port and an external arbiter that
// raises arb_grant when this channel wins and the engine owns the bus.
module dma_seq_top
    import dma_seq_pkg::*;
#(
    parameter int DW    = 32,
    parameter int CNT_W = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [1:0]    cfg_sel,
    input  logic [DW-1:0] cfg_wdata,
    input  logic          en_set,
    input  logic          en_clr,
    output logic          ch_active,
    input  logic          src_req,
    input  logic          src_last,
    input  logic          dst_req,
    input  logic          dst_last,
    output logic          src_ack,
    output logic          dst_ack,
    output logic          arb_pending,
    input  logic          arb_grant,
    output logic          bus_req,
    output logic          bus_we,
    output logic [DW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_done,
    input  logic          bus_err,
    output logic          irq_tc,
    output logic          irq_err
);
    logic [DW-1:0] src_q, dst_q, lli_q, ctrl_q;
    logic          req_hit, req_last, pflow_eff, ack_src_sel, ack_dst_sel;
    logic          beat_done, lli_wr;
    logic [1:0]    lli_sel;
    xfer_t         kind;

    assign kind = xfer_t'(ctrl_q[CW_KLO+1:CW_KLO]);

    dma_seq_regs #(.DW(DW), .CNT_W(CNT_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .busy(ch_active), .lli_wr(lli_wr),
        .lli_sel(lli_sel), .lli_data(bus_rdata), .beat_done(beat_done),
        .dec_en(!pflow_eff), .src_q(src_q), .dst_q(dst_q), .lli_q(lli_q),
        .ctrl_q(ctrl_q)
    );

    dma_seq_reqsel rsel_i (
        .kind(kind), .pflow_bit(ctrl_q[CW_PFLOW]), .src_req(src_req),
        .src_last(src_last), .dst_req(dst_req), .dst_last(dst_last),
        .req_hit(req_hit), .req_last(req_last), .pflow_eff(pflow_eff),
        .ack_src_sel(ack_src_sel), .ack_dst_sel(ack_dst_sel)
    );

    dma_seq_fsm #(.DW(DW), .CNT_W(CNT_W)) fsm_i (
        .clk(clk), .rst_n(rst_n), .en_set(en_set), .en_clr(en_clr),
        .arb_grant(arb_grant), .req_hit(req_hit), .req_last(req_last),
        .pflow_eff(pflow_eff), .ack_src_sel(ack_src_sel),
        .ack_dst_sel(ack_dst_sel), .tc_ie(ctrl_q[CW_TCIE]),
        .err_ie(ctrl_q[CW_ERRIE]), .cnt(ctrl_q[CNT_W-1:0]), .src_q(src_q),
        .dst_q(dst_q), .lli_q(lli_q), .bus_rdata(bus_rdata),
        .bus_done(bus_done), .bus_err(bus_err), .ch_active(ch_active),
        .arb_pending(arb_pending), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .beat_done(beat_done),
        .lli_wr(lli_wr), .lli_sel(lli_sel), .src_ack(src_ack),
        .dst_ack(dst_ack), .irq_tc(irq_tc), .irq_err(irq_err)
    );
endmodule

// File: rtl/dma_seq_chk.sv
// Protocol checker for the DMA channel sequencer, bound to the top.
// Watches the bus port, grant, status and interrupt pulses only.
module dma_seq_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ch_active,
    input logic          arb_grant,
    input logic          bus_req,
    input logic          bus_we,
    input logic          bus_done,
    input logic [DW-1:0] bus_addr,
    input logic          src_ack,
    input logic          dst_ack,
    input logic          irq_tc,
    input logic          irq_err
);
    // R4
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_done |=> bus_req && $stable(bus_addr) && $stable(bus_we));
    // R3
    grant_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> $past(arb_grant));
    // R8
    err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err |-> !ch_active && !bus_req);
    // R6
    irq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_tc && irq_err));
    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_active |-> !bus_req);
    // R6
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_ack || dst_ack) |=> !src_ack && !dst_ack);
endmodule

bind dma_seq_top dma_seq_chk #(.DW(DW)) chk_i (
    .clk(clk), .rst_n(rst_n), .ch_active(ch_active), .arb_grant(arb_grant),
    .bus_req(bus_req), .bus_we(bus_we), .bus_done(bus_done),
    .bus_addr(bus_addr), .src_ack(src_ack), .dst_ack(dst_ack),
    .irq_tc(irq_tc), .irq_err(irq_err)
);

// File: tb/dma_seq_top_tb_top.sv
// Bench for the DMA channel sequencer: memory model on the bus port,
// random memory copies plus directed request, chain, error and abort cases.
module dma_seq_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic        en_set = 1'b0, en_clr = 1'b0;
    logic        src_req = 1'b0, src_last = 1'b0, dst_req = 1'b0, dst_last = 1'b0;
    logic        arb_grant = 1'b1;
    logic        bus_done = 1'b0, bus_err = 1'b0;
    logic [31:0] bus_rdata = '0;
    logic        ch_active, src_ack, dst_ack, arb_pending, bus_req, bus_we;
    logic        irq_tc, irq_err;
    logic [31:0] bus_addr, bus_wdata;

    logic [31:0] mem [256];
    logic [31:0] exp_mem [256];
    logic        err_en = 1'b0;
    logic [31:0] err_addr = '0;
    int          lat = 0;
    int          wr_cnt = 0, tc_cnt = 0, er_cnt = 0, sack_cnt = 0, dack_cnt = 0;
    int          busy_cyc = 0, fetch_cnt = 0;
    int          chk_n = 0, fail_n = 0;
    bit          finished = 1'b0;

    always #4 clk = ~clk;

    dma_seq_top dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .en_set(en_set), .en_clr(en_clr),
        .ch_active(ch_active), .src_req(src_req), .src_last(src_last),
        .dst_req(dst_req), .dst_last(dst_last), .src_ack(src_ack),
        .dst_ack(dst_ack), .arb_pending(arb_pending), .arb_grant(arb_grant),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_done(bus_done),
        .bus_err(bus_err), .irq_tc(irq_tc), .irq_err(irq_err)
    );

    // Memory slave with random latency, error injection and event counters.
    always @(posedge clk) begin
        if (irq_tc) tc_cnt <= tc_cnt + 1;
        if (irq_err) er_cnt <= er_cnt + 1;
        if (src_ack) sack_cnt <= sack_cnt + 1;
        if (dst_ack) dack_cnt <= dack_cnt + 1;
        if (bus_req) busy_cyc <= busy_cyc + 1;
        if (bus_done && !bus_err && bus_we) wr_cnt <= wr_cnt + 1;
        if (bus_done && !bus_err && !bus_we && bus_addr >= 32'h320 && bus_addr <= 32'h32C)
            fetch_cnt <= fetch_cnt + 1;
        if (bus_done) begin
            bus_done <= 1'b0;
            bus_err  <= 1'b0;
            lat      <= int'($urandom_range(2, 0));
        end else if (bus_req && rst_n) begin
            if (lat == 0) begin
                bus_done <= 1'b1;
                if (err_en && bus_addr == err_addr) bus_err <= 1'b1;
                else if (bus_we) mem[bus_addr[9:2]] <= bus_wdata;
                else bus_rdata <= mem[bus_addr[9:2]];
            end else begin
                lat <= lat - 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        chk_n++;
        if (!ok) begin
            fail_n++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_ctrl(int cnt, bit si, bit di, int kind,
                                            bit pf, bit tcie, bit erie);
        logic [31:0] w = '0;
        w[15:0] = cnt[15:0];
        w[25] = erie; w[26] = si; w[27] = di;
        w[29:28] = kind[1:0]; w[30] = pf; w[31] = tcie;
        return w;
    endfunction

    function automatic void model_copy(int s, int d, int n, bit si, bit di);
        for (int i = 0; i < n; i++)
            exp_mem[((d + (di ? 4*i : 0)) >> 2) & 255] = exp_mem[((s + (si ? 4*i : 0)) >> 2) & 255];
    endfunction

    function automatic int mismatches();
        int m = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) m++;
        return m;
    endfunction

    function automatic void sync_model();
        for (int i = 0; i < 256; i++) exp_mem[i] = mem[i];
    endfunction

    task automatic cfg(input int sel, input logic [31:0] val);
        @(negedge clk); cfg_wr = 1'b1; cfg_sel = sel[1:0]; cfg_wdata = val;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic program_ch(input logic [31:0] s, d, l, c);
        cfg(0, s); cfg(1, d); cfg(2, l); cfg(3, c);
    endtask

    task automatic enable_ch();
        @(negedge clk); en_set = 1'b1;
        @(negedge clk); en_set = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000 && ch_active; i++) @(negedge clk);
        @(negedge clk);
    endtask

    // One request-paced beat: hold the request until the read starts, then wait for the write.
    task automatic peri_beat(input bit side_src, input bit last);
        int w0 = wr_cnt;
        @(negedge clk);
        if (side_src) begin src_req = 1'b1; src_last = last; end
        else begin dst_req = 1'b1; dst_last = last; end
        for (int i = 0; i < 200 && !bus_req; i++) @(negedge clk);
        src_req = 1'b0; src_last = 1'b0; dst_req = 1'b0; dst_last = 1'b0;
        for (int i = 0; i < 200 && wr_cnt == w0; i++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            chk_n++; fail_n++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", chk_n, fail_n);
            $finish;
        end
    end

    initial begin
        int w0, t0, e0, s0, d0, b0;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) mem[i] = $urandom;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state (R7: inactive channel makes no bus access)
        check(!ch_active && !bus_req && !irq_tc && !irq_err, "R7 reset",
              int'({ch_active, bus_req, irq_tc, irq_err}), 0);

        // R4 R5 R10: random memory-to-memory copies against the bench model
        for (int it = 0; it < 8; it++) begin
            int n = int'($urandom_range(6, 1));
            int s = 4 * int'($urandom_range(24, 0));
            int d = 32'h100 + 4 * int'($urandom_range(24, 0));
            bit si = 1'($urandom), di = 1'($urandom), pf = 1'($urandom);
            for (int i = 0; i < 32; i++) mem[i] = $urandom;
            sync_model();
            model_copy(s, d, n, si, di);
            w0 = wr_cnt; t0 = tc_cnt;
            program_ch(s, d, 0, mk_ctrl(n, si, di, 0, pf, 1, 1));
            enable_ch();
            wait_idle();
            check(mismatches() == 0, "R4 copy data", mismatches(), 0);
            check(wr_cnt - w0 == n, "R5 R10 beat count", wr_cnt - w0, n);
            check(tc_cnt - t0 == 1 && !ch_active, "R6 R7 tc and stop", tc_cnt - t0, 1);
        end

        // R2 R5 R6: memory-to-peripheral, peripheral flow, count field 1 ignored
        w0 = wr_cnt; d0 = dack_cnt; s0 = sack_cnt; t0 = tc_cnt; b0 = busy_cyc;
        program_ch(32'h010, 32'h300, 0, mk_ctrl(1, 1, 0, 1, 1, 1, 0));
        enable_ch();
        repeat (20) @(negedge clk);
        check(ch_active && busy_cyc == b0, "R2 waits without request", busy_cyc - b0, 0);
        src_req = 1'b1;
        repeat (10) @(negedge clk);
        src_req = 1'b0;
        check(busy_cyc == b0, "R2 wrong-side request ignored", busy_cyc - b0, 0);
        peri_beat(1'b0, 1'b0);
        peri_beat(1'b0, 1'b0);
        check(ch_active, "R5 count ignored under peripheral flow", int'(ch_active), 1);
        peri_beat(1'b0, 1'b1);
        wait_idle();
        check(wr_cnt - w0 == 3, "R5 last flag ends transfer", wr_cnt - w0, 3);
        check(dack_cnt - d0 == 1 && sack_cnt == s0, "R6 dst ack only", dack_cnt - d0, 1);
        check(tc_cnt - t0 == 1, "R6 tc on completion", tc_cnt - t0, 1);

        // R3: no beat without grant
        arb_grant = 1'b0;
        w0 = wr_cnt; b0 = busy_cyc;
        program_ch(32'h000, 32'h180, 0, mk_ctrl(2, 1, 1, 0, 0, 0, 0));
        enable_ch();
        repeat (15) @(negedge clk);
        check(busy_cyc == b0 && arb_pending, "R3 held off by grant", busy_cyc - b0, 0);
        arb_grant = 1'b1;
        wait_idle();
        check(wr_cnt - w0 == 2, "R3 runs after grant", wr_cnt - w0, 2);

        // R1: write during activity ignored; peripheral-to-memory, engine flow
        mem[192] = 32'hA5A5_0001; mem[252] = 32'h5A5A_0002;
        sync_model();
        model_copy(32'h300, 32'h1C0, 2, 0, 1);
        s0 = sack_cnt;
        program_ch(32'h300, 32'h1C0, 0, mk_ctrl(2, 0, 1, 2, 0, 0, 0));
        enable_ch();
        cfg(0, 32'h3F0);
        peri_beat(1'b1, 1'b0);
        peri_beat(1'b1, 1'b0);
        wait_idle();
        check(mismatches() == 0, "R1 busy write ignored", mismatches(), 0);
        check(sack_cnt - s0 == 1, "R6 src ack", sack_cnt - s0, 1);

        // R2 R6: peripheral-to-peripheral, source-paced, both acked
        s0 = sack_cnt; d0 = dack_cnt; w0 = wr_cnt;
        program_ch(32'h300, 32'h304, 0, mk_ctrl(9, 0, 0, 3, 1, 0, 0));
        enable_ch();
        peri_beat(1'b1, 1'b0);
        peri_beat(1'b1, 1'b1);
        wait_idle();
        check(wr_cnt - w0 == 2 && !ch_active, "R2 source-paced two beats", wr_cnt - w0, 2);
        check(sack_cnt - s0 == 1 && dack_cnt - d0 == 1, "R6 both acked",
              sack_cnt - s0 + dack_cnt - d0, 2);

        // R7: chained item at 0x320 reloads registers and re-arms
        for (int i = 0; i < 32; i++) mem[i] = $urandom;
        mem[200] = 32'h040; mem[201] = 32'h1A0; mem[202] = 32'h0;
        mem[203] = mk_ctrl(3, 1, 1, 0, 0, 1, 0);
        sync_model();
        model_copy(32'h000, 32'h100, 2, 1, 1);
        model_copy(32'h040, 32'h1A0, 3, 1, 1);
        t0 = tc_cnt; b0 = fetch_cnt; w0 = wr_cnt;
        program_ch(32'h000, 32'h100, 32'h320, mk_ctrl(2, 1, 1, 0, 0, 1, 0));
        enable_ch();
        wait_idle();
        check(mismatches() == 0, "R7 both items copied", mismatches(), 0);
        check(fetch_cnt - b0 == 4, "R7 four item reads", fetch_cnt - b0, 4);
        check(tc_cnt - t0 == 2 && wr_cnt - w0 == 5, "R7 two completions", tc_cnt - t0, 2);

        // R8: bus error on second beat, interrupt enabled then masked
        for (int k = 0; k < 2; k++) begin
            w0 = wr_cnt; e0 = er_cnt; t0 = tc_cnt;
            err_en = 1'b1; err_addr = 32'h024;
            program_ch(32'h020, 32'h140, 0, mk_ctrl(4, 1, 1, 0, 0, 1, (k == 0)));
            enable_ch();
            wait_idle();
            err_en = 1'b0;
            check(!ch_active && wr_cnt - w0 == 1, "R8 stop after error", wr_cnt - w0, 1);
            check(er_cnt - e0 == (k == 0 ? 1 : 0) && tc_cnt == t0, "R8 error irq mask",
                  er_cnt - e0, (k == 0 ? 1 : 0));
        end

        // R9: disable while waiting, then while running
        t0 = tc_cnt;
        program_ch(32'h300, 32'h100, 0, mk_ctrl(5, 0, 1, 2, 0, 1, 0));
        enable_ch();
        repeat (5) @(negedge clk);
        en_clr = 1'b1; @(negedge clk); en_clr = 1'b0;
        repeat (2) @(negedge clk);
        check(!ch_active && tc_cnt == t0, "R9 abort while waiting", int'(ch_active), 0);
        w0 = wr_cnt;
        program_ch(32'h000, 32'h100, 0, mk_ctrl(40, 0, 0, 0, 0, 1, 0));
        enable_ch();
        repeat (20) @(negedge clk);
        en_clr = 1'b1; @(negedge clk); en_clr = 1'b0;
        wait_idle();
        check(!ch_active && wr_cnt - w0 > 0 && wr_cnt - w0 < 40, "R9 abort mid-transfer",
              wr_cnt - w0, 20);
        check(tc_cnt == t0, "R9 no tc after abort", tc_cnt - t0, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", chk_n, fail_n);
        $finish;
    end
endmodule